// File: doc/BRIEF.md
# Legacy Address Range Router

This block decides where each host memory request in the first megabyte, and in the 15 MB to 16 MB window, should go. Each request carries an address, a read/write flag, an SMM flag and a flag that says whether it came from the host or from the hub/graphics side. For every valid request the block raises exactly one of four outputs: DRAM, PCI, AGP or reject. The decision is purely combinational from the request and the stored control state.

The control state is held in a small byte-wide configuration port with a write strobe and a read strobe. It holds a two-bit read/write attribute for each of thirteen shadow segments, an enable for the 15 MB hole, an enable for the 80000h–9FFFFh hole, an SMRAM enable and a bit that steers the video window to the graphics side. Everything resets to zero, so after reset the shadow segments route to PCI and every other range routes to DRAM, except the video window, which routes to PCI.

Top module: `legacy_route`

## Requirements
- R1: Requests below 80000h route to DRAM for every value of the control state, the write flag, the SMM flag and the host flag.
- R2: Requests in 80000h–9FFFFh route to DRAM while the low-hole enable (bit 0 at offset 9Dh) is clear, and to PCI while it is set.
- R3: Requests in A0000h–BFFFFh that take no SMRAM path route to PCI when the video select (bit 2 at offset 9Dh) is clear and to AGP when it is set. Segment attributes have no effect there.
- R4: With SMRAM enabled (bit 1 at offset 9Dh), a host request in SMM to A0000h–BFFFFh routes to DRAM, and a non-host request to that range raises reject. A host request outside SMM follows R3.
- R5: C0000h–DFFFFh forms eight 16 KB segments, numbered 0–7 by rising address. Segment n's two-bit attribute sits at offset 90h + n/4, bits 2*(n%4)+1:2*(n%4). Attribute bit 0 set sends reads to DRAM, and clear sends them to PCI. Attribute bit 1 does the same for writes.
- R6: E0000h–EFFFFh forms segments 8–11 with 16 KB each, at offset 92h. F0000h–FFFFFh is one segment, 12, whose attribute sits in bits 1:0 of offset 93h. Both follow the encoding of R5.
- R7: The hole register at offset 97h resets to 00h and stores only bit 7. Bits 6:0 read as zero whatever was written. Bits 7:2 of offset 93h also read as zero.
- R8: With the hole enable set, requests in F00000h–FFFFFFh route to PCI. With it clear, they route to DRAM. Other requests at or above 100000h always route to DRAM.
- R9: A configuration write changes routing only after the next rising clock edge. A request in the cycle of the write sees the old setting. A read strobe loads cfg_rdata at the next rising edge. Unmapped offsets read 00h.
- R10: While req_valid is high, exactly one of sel_dram, sel_pci, sel_agp and sel_reject is high. While req_valid is low, none of them is high.
- R11: After reset, every readable offset (90h–93h, 97h, 9Dh) reads 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data, loaded on a read strobe |
| req_valid | input | 1 | Request present |
| req_addr | input | ADDR_W | Request byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_smm | input | 1 | Request issued in SMM |
| req_host | input | 1 | 1 = host request, 0 = hub/graphics side |
| sel_dram | output | 1 | Route to DRAM |
| sel_pci | output | 1 | Route to PCI |
| sel_agp | output | 1 | Route to AGP |
| sel_reject | output | 1 | Request refused |

## Verification
A configuration write and a routing request can arrive in the same cycle. The router must then route from the old setting and switch only after the edge. The bench provokes this by raising the write strobe for the video select together with a request into the video window. It samples the route just before the rising edge and expects PCI, then samples again just after the edge and expects AGP. The same overlap is also exercised on the hole register with a request at F00000h.

// File: rtl/legacy_route_pkg.sv
`timescale 1ns/1ps
package legacy_route_pkg;

  localparam int SEG_COUNT = 13;
  localparam int ATTR_W    = 2;
  localparam int SEG_IW    = $clog2(SEG_COUNT);
  localparam int ATTR_FLAT = SEG_COUNT * ATTR_W;
  localparam int SEGS_PER_BYTE = 8 / ATTR_W;

  localparam logic [7:0] OFS_ATTR0 = 8'h90;
  localparam logic [7:0] OFS_HOLE  = 8'h97;
  localparam logic [7:0] OFS_CTRL  = 8'h9D;

  localparam int CTRL_LOW   = 0;
  localparam int CTRL_SMRAM = 1;
  localparam int CTRL_VGA   = 2;
  localparam int HOLE_BIT   = 7;

  localparam logic [31:0] LIM_BASE  = 32'h0008_0000;
  localparam logic [31:0] LIM_LOW   = 32'h000A_0000;
  localparam logic [31:0] LIM_VIDEO = 32'h000C_0000;
  localparam logic [31:0] LIM_SEG   = 32'h0010_0000;
  localparam logic [31:0] HOLE_LO   = 32'h00F0_0000;
  localparam logic [31:0] HOLE_HI   = 32'h0100_0000;
  localparam int SEG_SHIFT  = 14;
  localparam int SEG_FIRST  = 48;
  localparam int SEG_LAST   = SEG_COUNT - 1;

  typedef enum logic [2:0] {
    RG_BASE, RG_LOWHOLE, RG_VIDEO, RG_SEG, RG_HOLE, RG_EXT
  } region_e;

  typedef enum logic [1:0] {
    TGT_DRAM = 2'd0, TGT_PCI = 2'd1, TGT_AGP = 2'd2, TGT_REJECT = 2'd3
  } target_e;

  function automatic region_e classify(input logic [31:0] a);
    if (a < LIM_BASE)                     return RG_BASE;
    else if (a < LIM_LOW)                 return RG_LOWHOLE;
    else if (a < LIM_VIDEO)               return RG_VIDEO;
    else if (a < LIM_SEG)                 return RG_SEG;
    else if (a >= HOLE_LO && a < HOLE_HI) return RG_HOLE;
    else                                  return RG_EXT;
  endfunction

  function automatic logic [SEG_IW-1:0] seg_index(input logic [31:0] a);
    int blk;
    blk = int'(a >> SEG_SHIFT) - SEG_FIRST;
    if (blk > SEG_LAST) blk = SEG_LAST;
    if (blk < 0) blk = 0;
    return SEG_IW'(blk);
  endfunction

  function automatic target_e attr_target(input logic [ATTR_W-1:0] attr,
                                          input logic wr);
    logic to_dram;
    to_dram = wr ? attr[1] : attr[0];
    return to_dram ? TGT_DRAM : TGT_PCI;
  endfunction

  function automatic logic [3:0] tgt_onehot(input target_e t);
    return 4'b0001 << t;
  endfunction

endpackage

// File: rtl/legacy_route_cfg.sv
`timescale 1ns/1ps
module legacy_route_cfg
  import legacy_route_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr,
  input  logic                 cfg_rd,
  input  logic [7:0]           cfg_addr,
  input  logic [7:0]           cfg_wdata,
  output logic [7:0]           cfg_rdata,
  output logic [ATTR_FLAT-1:0] attr_flat,
  output logic                 hole_en,
  output logic                 low_hole_en,
  output logic                 smram_en,
  output logic                 vga_agp
);

  for (genvar g = 0; g < SEG_COUNT; g++) begin : g_seg
    localparam logic [7:0] SEG_OFS = OFS_ATTR0 + 8'(g / SEGS_PER_BYTE);
    localparam int         SEG_LSB = ATTR_W * (g % SEGS_PER_BYTE);
    logic [ATTR_W-1:0] attr_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        attr_q <= '0;
      else if (cfg_wr && cfg_addr == SEG_OFS)
        attr_q <= cfg_wdata[SEG_LSB +: ATTR_W];
    end
    assign attr_flat[g*ATTR_W +: ATTR_W] = attr_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hole_en <= 1'b0;
    end else if (cfg_wr && cfg_addr == OFS_HOLE) begin
      hole_en <= cfg_wdata[HOLE_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_hole_en <= 1'b0;
      smram_en    <= 1'b0;
      vga_agp     <= 1'b0;
    end else if (cfg_wr && cfg_addr == OFS_CTRL) begin
      low_hole_en <= cfg_wdata[CTRL_LOW];
      smram_en    <= cfg_wdata[CTRL_SMRAM];
      vga_agp     <= cfg_wdata[CTRL_VGA];
    end
  end

  logic [7:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    for (int s = 0; s < SEG_COUNT; s++) begin
      if (cfg_addr == OFS_ATTR0 + 8'(s / SEGS_PER_BYTE))
        rd_mux[ATTR_W*(s % SEGS_PER_BYTE) +: ATTR_W] = attr_flat[s*ATTR_W +: ATTR_W];
    end
    if (cfg_addr == OFS_HOLE) rd_mux[HOLE_BIT] = hole_en;
    if (cfg_addr == OFS_CTRL) begin
      rd_mux[CTRL_LOW]   = low_hole_en;
      rd_mux[CTRL_SMRAM] = smram_en;
      rd_mux[CTRL_VGA]   = vga_agp;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg_rdata <= '0;
    else if (cfg_rd) cfg_rdata <= rd_mux;
  end

endmodule

// File: rtl/legacy_route_segsel.sv
`timescale 1ns/1ps
module legacy_route_segsel
  import legacy_route_pkg::*;
(
  input  logic [31:0]          addr_x,
  input  logic [ATTR_FLAT-1:0] attr_flat,
  output logic [ATTR_W-1:0]    seg_attr
);

  logic [SEG_IW-1:0] idx;
  assign idx = seg_index(addr_x);

  always_comb begin
    seg_attr = '0;
    for (int s = 0; s < SEG_COUNT; s++) begin
      if (idx == SEG_IW'(s)) seg_attr = attr_flat[s*ATTR_W +: ATTR_W];
    end
  end

endmodule

// File: rtl/legacy_route_decode.sv
`timescale 1ns/1ps
module legacy_route_decode
  import legacy_route_pkg::*;
(
  input  logic              valid,
  input  logic [31:0]       addr_x,
  input  logic              is_write,
  input  logic              is_smm,
  input  logic              is_host,
  input  logic [ATTR_W-1:0] seg_attr,
  input  logic              hole_en,
  input  logic              low_hole_en,
  input  logic              smram_en,
  input  logic              vga_agp,
  output region_e           region,
  output logic [3:0]        sel
);

  target_e tgt;

  assign region = classify(addr_x);

  always_comb begin
    tgt = TGT_DRAM;
    unique case (region)
      RG_BASE, RG_EXT: tgt = TGT_DRAM;
      RG_LOWHOLE:      tgt = low_hole_en ? TGT_PCI : TGT_DRAM;
      RG_VIDEO: begin
        if (smram_en && !is_host)     tgt = TGT_REJECT;
        else if (smram_en && is_smm)  tgt = TGT_DRAM;
        else                          tgt = vga_agp ? TGT_AGP : TGT_PCI;
      end
      RG_SEG:          tgt = attr_target(seg_attr, is_write);
      RG_HOLE:         tgt = hole_en ? TGT_PCI : TGT_DRAM;
      default:         tgt = TGT_DRAM;
    endcase
  end

  assign sel = valid ? tgt_onehot(tgt) : 4'b0000;

endmodule

// File: rtl/legacy_route.sv
`timescale 1ns/1ps
module legacy_route
  import legacy_route_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [7:0]        cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_smm,
  input  logic              req_host,
  output logic              sel_dram,
  output logic              sel_pci,
  output logic              sel_agp,
  output logic              sel_reject
);

  logic [31:0]          addr_x;
  logic [ATTR_FLAT-1:0] attr_flat;
  logic [ATTR_W-1:0]    seg_attr;
  logic                 hole_en, low_hole_en, smram_en, vga_agp;
  region_e              region;
  logic [3:0]           sel;

  assign addr_x = 32'(req_addr);

  legacy_route_cfg u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .cfg_rd     (cfg_rd),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .attr_flat  (attr_flat),
    .hole_en    (hole_en),
    .low_hole_en(low_hole_en),
    .smram_en   (smram_en),
    .vga_agp    (vga_agp)
  );

  legacy_route_segsel u_segsel (
    .addr_x   (addr_x),
    .attr_flat(attr_flat),
    .seg_attr (seg_attr)
  );

  legacy_route_decode u_dec (
    .valid      (req_valid),
    .addr_x     (addr_x),
    .is_write   (req_write),
    .is_smm     (req_smm),
    .is_host    (req_host),
    .seg_attr   (seg_attr),
    .hole_en    (hole_en),
    .low_hole_en(low_hole_en),
    .smram_en   (smram_en),
    .vga_agp    (vga_agp),
    .region     (region),
    .sel        (sel)
  );

  assign sel_dram   = sel[TGT_DRAM];
  assign sel_pci    = sel[TGT_PCI];
  assign sel_agp    = sel[TGT_AGP];
  assign sel_reject = sel[TGT_REJECT];

endmodule

// File: rtl/legacy_route_checker.sv
`timescale 1ns/1ps
module legacy_route_checker
  import legacy_route_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr,
  input logic        cfg_rd,
  input logic [7:0]  cfg_addr,
  input logic [7:0]  cfg_wdata,
  input logic [7:0]  cfg_rdata,
  input logic        req_valid,
  input logic [31:0] addr_x,
  input logic        req_host,
  input logic        req_smm,
  input logic        hole_en,
  input logic        smram_en,
  input logic        sel_dram,
  input logic        sel_pci,
  input logic        sel_agp,
  input logic        sel_reject
);

  logic [3:0] sels;
  logic in_base, in_video, in_hole;
  assign sels     = {sel_reject, sel_agp, sel_pci, sel_dram};
  assign in_base  = addr_x < 32'h8_0000;
  assign in_video = addr_x >= 32'hA_0000 && addr_x <= 32'hB_FFFF;
  assign in_hole  = addr_x >= 32'hF0_0000 && addr_x <= 32'hFF_FFFF;

  p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $countones(sels) == 1);

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> sels == 4'b0000);

  p_base_dram_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && in_base) |-> sel_dram);

  p_smram_refuse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && in_video && smram_en && !req_host) |-> sel_reject);

  p_smram_dram_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && in_video && smram_en && req_host && req_smm) |-> sel_dram);

  p_hole_pci_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && in_hole && hole_en) |-> sel_pci);

  p_hole_rsvd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd && cfg_addr == OFS_HOLE) |=> cfg_rdata[6:0] == 7'd0);

  p_cfg_next_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr == OFS_HOLE) |=> hole_en == $past(cfg_wdata[HOLE_BIT]));

endmodule

bind legacy_route legacy_route_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_wr    (cfg_wr),
  .cfg_rd    (cfg_rd),
  .cfg_addr  (cfg_addr),
  .cfg_wdata (cfg_wdata),
  .cfg_rdata (cfg_rdata),
  .req_valid (req_valid),
  .addr_x    (addr_x),
  .req_host  (req_host),
  .req_smm   (req_smm),
  .hole_en   (hole_en),
  .smram_en  (smram_en),
  .sel_dram  (sel_dram),
  .sel_pci   (sel_pci),
  .sel_agp   (sel_agp),
  .sel_reject(sel_reject)
);

// File: tb/legacy_route_test.sv
`timescale 1ns/1ps
module legacy_route_test;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic        cfg_wr, cfg_rd;
  logic [7:0]  cfg_addr, cfg_wdata, cfg_rdata;
  logic        req_valid, req_write, req_smm, req_host;
  logic [23:0] req_addr;
  logic        sel_dram, sel_pci, sel_agp, sel_reject;

  legacy_route #(.ADDR_W(24)) uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
    .req_smm(req_smm), .req_host(req_host),
    .sel_dram(sel_dram), .sel_pci(sel_pci), .sel_agp(sel_agp),
    .sel_reject(sel_reject)
  );

  // route codes used by the bench: 0 none, 1 DRAM, 2 PCI, 3 AGP, 4 reject
  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [1:0] m_attr [13];
  bit m_hole, m_low, m_smram, m_vga;

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int exp_route(input logic [23:0] a, input bit wr,
                                   input bit smm, input bit host);
    int s;
    logic [1:0] at;
    if (a <= 24'h07FFFF) return 1;
    if (a <= 24'h09FFFF) return m_low ? 2 : 1;
    if (a <= 24'h0BFFFF) begin
      if (m_smram && !host) return 4;
      if (m_smram && smm)   return 1;
      return m_vga ? 3 : 2;
    end
    if (a <= 24'h0FFFFF) begin
      s = int'((a - 24'h0C0000) / 24'h004000);
      if (s > 12) s = 12;
      at = m_attr[s];
      if (wr) return at[1] ? 1 : 2;
      return at[0] ? 1 : 2;
    end
    if (a >= 24'hF00000) return m_hole ? 2 : 1;
    return 1;
  endfunction

  function automatic int got_route();
    case ({sel_reject, sel_agp, sel_pci, sel_dram})
      4'b0000: return 0;
      4'b0001: return 1;
      4'b0010: return 2;
      4'b0100: return 3;
      4'b1000: return 4;
      default: return 15;
    endcase
  endfunction

  function automatic logic [7:0] model_read(input logic [7:0] a);
    case (a)
      8'h90: return {m_attr[3], m_attr[2], m_attr[1], m_attr[0]};
      8'h91: return {m_attr[7], m_attr[6], m_attr[5], m_attr[4]};
      8'h92: return {m_attr[11], m_attr[10], m_attr[9], m_attr[8]};
      8'h93: return {6'd0, m_attr[12]};
      8'h97: return {m_hole, 7'd0};
      8'h9D: return {5'd0, m_vga, m_smram, m_low};
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_write(input logic [7:0] a, input logic [7:0] d);
    case (a)
      8'h90: for (int k = 0; k < 4; k++) m_attr[k]     = d[2*k +: 2];
      8'h91: for (int k = 0; k < 4; k++) m_attr[4 + k] = d[2*k +: 2];
      8'h92: for (int k = 0; k < 4; k++) m_attr[8 + k] = d[2*k +: 2];
      8'h93: m_attr[12] = d[1:0];
      8'h97: m_hole = d[7];
      8'h9D: begin m_low = d[0]; m_smram = d[1]; m_vga = d[2]; end
      default: ;
    endcase
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
    model_write(a, d);
  endtask

  task automatic cfg_read_chk(input string tag, input logic [7:0] a);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_addr = a;
    @(negedge clk);
    cfg_rd = 1'b0;
    chk(tag, int'(cfg_rdata), int'(model_read(a)));
  endtask

  task automatic check_route(input string tag, input logic [23:0] a,
                             input bit wr, input bit smm, input bit host);
    req_valid = 1'b1; req_addr = a; req_write = wr; req_smm = smm; req_host = host;
    #1;
    chk(tag, got_route(), exp_route(a, wr, smm, host));
  endtask

  task automatic t_reset();
    req_valid = 1'b0; req_addr = 24'h0A0000;
    #1;
    chk("R10 idle after reset", got_route(), 0);
    cfg_read_chk("R11 reset 90h", 8'h90);
    cfg_read_chk("R11 reset 93h", 8'h93);
    cfg_read_chk("R11 reset 97h", 8'h97);
    cfg_read_chk("R11 reset 9Dh", 8'h9D);
    check_route("R11 default video to PCI", 24'h0A0000, 0, 0, 1);
    check_route("R11 default segment read PCI", 24'h0C0000, 0, 0, 1);
  endtask

  task automatic t_base();
    cfg_write(8'h9D, 8'h07);
    cfg_write(8'h97, 8'h80);
    cfg_write(8'h90, 8'h00);
    check_route("R1 address 0", 24'h000000, 0, 0, 1);
    check_route("R1 top of 512K", 24'h07FFFF, 1, 1, 0);
    check_route("R1 mid write smm", 24'h040000, 1, 1, 1);
    chk("R1 dram literal", got_route(), 1);
  endtask

  task automatic t_low_hole();
    cfg_write(8'h9D, 8'h00);
    check_route("R2 low hole off start", 24'h080000, 0, 0, 1);
    chk("R2 low hole off is DRAM", got_route(), 1);
    cfg_write(8'h9D, 8'h01);
    check_route("R2 low hole on start", 24'h080000, 0, 0, 1);
    check_route("R2 low hole on end", 24'h09FFFF, 1, 0, 1);
    chk("R2 low hole on is PCI", got_route(), 2);
  endtask

  task automatic t_video();
    cfg_write(8'h90, 8'hFF);
    cfg_write(8'h9D, 8'h00);
    check_route("R3 video to PCI", 24'h0A0000, 0, 0, 1);
    chk("R3 PCI literal", got_route(), 2);
    cfg_write(8'h9D, 8'h04);
    check_route("R3 video to AGP", 24'h0BFFFF, 1, 0, 1);
    chk("R3 AGP literal", got_route(), 3);
    check_route("R3 smm without smram", 24'h0B0000, 0, 1, 1);
  endtask

  task automatic t_smram();
    cfg_write(8'h9D, 8'h06);
    check_route("R4 smm host to DRAM", 24'h0A8000, 0, 1, 1);
    chk("R4 DRAM literal", got_route(), 1);
    check_route("R4 non-host refused", 24'h0A8000, 1, 0, 0);
    chk("R4 reject literal", got_route(), 4);
    check_route("R4 non-host smm refused", 24'h0BFFFF, 0, 1, 0);
    check_route("R4 host non-smm to AGP", 24'h0A0000, 0, 0, 1);
    cfg_write(8'h9D, 8'h00);
    check_route("R4 smram off non-host", 24'h0A0000, 0, 0, 0);
  endtask

  task automatic t_segments();
    cfg_write(8'h90, 8'b11_10_01_00);
    cfg_write(8'h91, 8'b00_01_10_11);
    cfg_read_chk("R5 readback 90h", 8'h90);
    cfg_read_chk("R5 readback 91h", 8'h91);
    for (int s = 0; s < 8; s++) begin
      for (int w = 0; w < 2; w++) begin
        check_route($sformatf("R5 seg%0d start w%0d", s, w),
                    24'h0C0000 + 24'(s) * 24'h4000, w[0], 0, 1);
        check_route($sformatf("R5 seg%0d end w%0d", s, w),
                    24'h0C0000 + 24'(s) * 24'h4000 + 24'h3FFF, w[0], 0, 1);
      end
    end
  endtask

  task automatic t_ext();
    cfg_write(8'h92, 8'b01_11_00_10);
    cfg_write(8'h93, 8'hFE);
    cfg_read_chk("R6 readback 92h", 8'h92);
    cfg_read_chk("R7 reserved bits of 93h", 8'h93);
    for (int s = 0; s < 4; s++) begin
      for (int w = 0; w < 2; w++)
        check_route($sformatf("R6 ext seg%0d w%0d", s, w),
                    24'h0E0000 + 24'(s) * 24'h4000 + 24'h2000, w[0], 0, 1);
    end
    check_route("R6 top segment read start", 24'h0F0000, 0, 0, 1);
    chk("R6 top read PCI", got_route(), 2);
    check_route("R6 top segment write end", 24'h0FFFFF, 1, 0, 1);
    chk("R6 top write DRAM", got_route(), 1);
  endtask

  task automatic t_hole_reg();
    cfg_write(8'h97, 8'hFF);
    cfg_read_chk("R7 hole reads 80h", 8'h97);
    chk("R7 hole literal", int'(cfg_rdata), 8'h80);
    cfg_write(8'h97, 8'h7F);
    cfg_read_chk("R7 reserved ignored", 8'h97);
    chk("R7 zero literal", int'(cfg_rdata), 8'h00);
  endtask

  task automatic t_hole_route();
    cfg_write(8'h97, 8'h80);
    check_route("R8 hole start", 24'hF00000, 0, 0, 1);
    check_route("R8 hole end", 24'hFFFFFF, 1, 0, 1);
    chk("R8 hole PCI", got_route(), 2);
    check_route("R8 below hole", 24'hEFFFFF, 0, 0, 1);
    check_route("R8 at 1MB", 24'h100000, 1, 0, 1);
    chk("R8 1MB DRAM", got_route(), 1);
    cfg_write(8'h97, 8'h00);
    check_route("R8 hole disabled", 24'hF80000, 0, 0, 1);
  endtask

  task automatic t_same_cycle();
    cfg_write(8'h9D, 8'h00);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = 8'h9D; cfg_wdata = 8'h04;
    req_valid = 1'b1; req_addr = 24'h0A4000; req_write = 1'b0;
    req_smm = 1'b0; req_host = 1'b1;
    #1;
    chk("R9 same cycle sees old", got_route(), 2);
    @(posedge clk);
    #1;
    chk("R9 after edge sees new", got_route(), 3);
    @(negedge clk);
    cfg_wr = 1'b0;
    model_write(8'h9D, 8'h04);
    cfg_wr = 1'b1; cfg_addr = 8'h97; cfg_wdata = 8'h80;
    req_addr = 24'hF00000;
    #1;
    chk("R9 hole same cycle old", got_route(), 1);
    @(posedge clk);
    #1;
    chk("R9 hole after edge", got_route(), 2);
    @(negedge clk);
    cfg_wr = 1'b0;
    model_write(8'h97, 8'h80);
    cfg_read_chk("R9 unmapped reads zero", 8'h50);
    chk("R9 unmapped literal", int'(cfg_rdata), 0);
  endtask

  task automatic t_idle();
    req_valid = 1'b0; req_addr = 24'h0C0000;
    #1;
    chk("R10 no select when idle", got_route(), 0);
    check_route("R10 one select when valid", 24'h0C0000, 1, 0, 1);
    req_valid = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 13; k++) m_attr[k] = 2'b00;
    m_hole = 0; m_low = 0; m_smram = 0; m_vga = 0;
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_rd = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    req_valid = 1'b0; req_addr = '0; req_write = 1'b0; req_smm = 1'b0; req_host = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_base();
    t_low_hole();
    t_video();
    t_smram();
    t_segments();
    t_ext();
    t_hole_reg();
    t_hole_route();
    t_same_cycle();
    t_idle();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule